// File: doc/BRIEF.md
# Programmable 24-bit Counter/Timer Channel

One counter channel for a bus-mapped acquisition peripheral. The count is 24 bits wide and can go up or down. Two 24-bit preload values give it a reload source. A 16-bit mode word chooses the clock, the direction, the enable, the reload policy and the output. A write-only command word resets the count, loads it, or clears the capture flag (RCAP). Software reaches all of this through four 16-bit word addresses.

The count steps on a one-cycle internal tick or on a quadrature A/B pair decoded at x1, x2 or x4. The pair and an index input each pass through a two-flop synchronizer. The RCAP flag is set when a down-count reaches zero. It drives the output pin, and it can also gate the count enable. Together these let the channel act as a retriggerable one-shot, a pulse generator, or a position counter that reloads on an index mark.

Top module: `cnt24_channel`

## Requirements
- R1: After a synchronous active-low reset, the count and both preloads are 0, the mode word is 0 and RCAP is 1. The output therefore reads 1.
- R2: Word addresses map as follows: 0 returns count bits 15:0; 1 returns the high byte in bits 7:0 with bits 15:8 zero; 2 returns the last mode word written; 3 returns 0. The mode fields from bit 0 upward are:
  - output source (1 bit)
  - output polarity (1)
  - auto-load select (3)
  - hardware enable source (2)
  - enable control (2)
  - clock source (2)
  - direction (1)
  - direction control (1)
  - latch control (1)
  - preload select (1)
  - reserved (1)
- R3: Clock source 3 steps the count on each cycle with the tick input high. Direction control 1 takes the direction from the direction bit (0 up, 1 down); direction control 0 counts up on the tick. Enable control 0 blocks counting and 1 always enables it. Enable control 2 or 3 follows the hardware source: 0 is the enable pin, 1 is its inverse, 2 is RCAP and 3 is the inverse of RCAP.
- R4: A write to address 3 with bit 15 set clears the count. With bit 14 set and bit 15 clear, the count loads from preload 0. Both commands take effect at the edge of the write, and the reset wins when both bits are set.
- R5: A down step from 1 to 0 sets RCAP. A write to address 3 with bit 3 set clears RCAP, and the clear wins when both happen in the same cycle.
- R6: Mode bit 14 chooses which preload receives writes. Address 0 writes preload bits 15:0, and address 1 writes bits 23:16 from data bits 7:0.
- R7: With auto-load select 1, the cycle after a terminal count reloads the count from the preload chosen by mode bit 14.
- R8: Clock sources 0, 1 and 2 count quadrature transitions:
  - x1 counts only the 00/10 transitions of the {A,B} pair.
  - x2 counts every A transition.
  - x4 counts every legal transition.
  - The sequence 00, 10, 11, 01 counts up.
  - A change of both phases at once is not counted.
  - A pin change shows in the count three edges later.
- R9: With auto-load select 4, a rising index edge reloads the count from the selected preload three edges after the pin change. The reload takes priority over a step in the same cycle.
- R10: With latch control 0, address 1 returns the high byte captured at the last address-0 read. With latch control 1, it returns the live high byte.
- R11: The output is RCAP when mode bit 0 is 0, or the flag "count is zero" when it is 1. Mode bit 1 inverts the output.
- R12: With hardware source 3 and auto-load 1, clearing RCAP starts a down-count from the loaded value. At zero the count reloads and then stops until RCAP is cleared again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (latches the high byte on an address-0 read) |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| tick_in | input | 1 | Internal count tick, one cycle wide |
| quad_a | input | 1 | Quadrature phase A, asynchronous |
| quad_b | input | 1 | Quadrature phase B, asynchronous |
| index_in | input | 1 | Index mark, asynchronous |
| hw_enable | input | 1 | Hardware count enable |
| count_out | output | 1 | Channel output |

## Verification
Two pairs of events can fall in the same cycle.
- **Terminal count and RCAP clear.** A command write with bit 3 is issued in the same cycle as the tick that takes the count from 1 to 0. The bench then expects RCAP to stay clear and the count to sit at zero.
- **Index reload and quadrature step.** The index pin and phase A are changed on the same clock, so both reach the synchronizer outputs together. The count must then hold the preload value rather than that value plus one.

A behavioural model follows these priorities every cycle and compares the read data and the output pin.

// File: rtl/cnt24_pkg.sv
// Shared types and encodings for the 24-bit counter channel.
// Assumes a 16-bit data word; the mode word fills it exactly.
package cnt24_pkg;

    localparam int ADDR_W  = 2;
    localparam int NUM_PRE = 2;

    localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd3;

    localparam int CMD_RESET_BIT = 15;
    localparam int CMD_LOAD_BIT  = 14;
    localparam int CMD_FIRE_BIT  = 3;

    localparam logic [2:0] AL_OFF   = 3'd0;
    localparam logic [2:0] AL_TC    = 3'd1;
    localparam logic [2:0] AL_INDEX = 3'd4;

    localparam logic [1:0] CKS_X1  = 2'd0;
    localparam logic [1:0] CKS_X2  = 2'd1;
    localparam logic [1:0] CKS_X4  = 2'd2;
    localparam logic [1:0] CKS_INT = 2'd3;

    // Mode word; the last field listed sits at bit 0.
    typedef struct packed {
        logic       rsvd;
        logic       psel;
        logic       latch_live;
        logic       dir_sw;
        logic       dir_down;
        logic [1:0] clk_src;
        logic [1:0] en_ctl;
        logic [1:0] hw_src;
        logic [2:0] autoload;
        logic       out_pol;
        logic       out_src;
    } mode_t;

endpackage

// File: rtl/cnt24_sync.sv
// Multi-bit synchronizer chain for asynchronous pins.
// Assumes each bit is independent (no bus coherence needed); STAGES >= 2.
module cnt24_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cnt24_quad.sv
// Quadrature decoder: compares synchronized A/B with the previous sample
// and reports one legal step plus its direction, filtered by multiplier.
// Assumes inputs are already synchronized to clk.
module cnt24_quad
    import cnt24_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a_s,
    input  logic       b_s,
    input  logic [1:0] mult,
    output logic       step,
    output logic       up
);
    logic a_q, b_q;
    logic a_chg, b_chg, legal;

    // Hold the previous synchronized phase pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= a_s;
            b_q <= b_s;
        end
    end

    assign a_chg = a_s ^ a_q;
    assign b_chg = b_s ^ b_q;
    assign legal = a_chg ^ b_chg;
    assign up    = ~(a_q ^ b_s);

    // Select which legal transitions count for the chosen multiplier.
    always_comb begin
        unique case (mult)
            CKS_X1:  step = a_chg & legal & ~b_s;
            CKS_X2:  step = a_chg & legal;
            CKS_X4:  step = legal;
            default: step = 1'b0;
        endcase
    end

    AST_QUAD_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (a_chg && b_chg) |-> !step); // R8
endmodule

// File: rtl/cnt24_regs.sv
// Register window: mode word, banked preloads behind one high/low window,
// command decode and readback with optional high-byte latch.
// Assumes one access per cycle and DATA_W equal to the mode word width.
module cnt24_regs
    import cnt24_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output mode_t             mode,
    output logic [CNT_W-1:0]  pre_sel,
    output logic [CNT_W-1:0]  pre0,
    output logic              cmd_reset,
    output logic              cmd_load,
    output logic              cmd_fire
);
    localparam int HI_W = CNT_W - DATA_W;

    mode_t           mode_q;
    logic [HI_W-1:0] hold_q;

    // Store the mode word.
    always_ff @(posedge clk) begin
        if (!rst_n)                           mode_q <= '0;
        else if (wr_en && addr == ADDR_MODE)  mode_q <= mode_t'(wdata);
    end

    // One preload per bank; the mode select bit steers window writes.
    for (genvar p = 0; p < NUM_PRE; p++) begin : g_pre
        logic [CNT_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en && mode_q.psel == 1'(p)) begin
                if (addr == ADDR_LO) val_q[DATA_W-1:0]     <= wdata;
                if (addr == ADDR_HI) val_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
            end
        end
    end

    // Capture the high byte when the low word is read.
    always_ff @(posedge clk) begin
        if (!rst_n)                         hold_q <= '0;
        else if (rd_en && addr == ADDR_LO)  hold_q <= count[CNT_W-1:DATA_W];
    end

    assign mode      = mode_q;
    assign pre0      = g_pre[0].val_q;
    assign pre_sel   = mode_q.psel ? g_pre[1].val_q : g_pre[0].val_q;
    assign cmd_reset = wr_en && addr == ADDR_CMD && wdata[CMD_RESET_BIT];
    assign cmd_load  = wr_en && addr == ADDR_CMD && wdata[CMD_LOAD_BIT];
    assign cmd_fire  = wr_en && addr == ADDR_CMD && wdata[CMD_FIRE_BIT];

    // Return the addressed word.
    always_comb begin
        unique case (addr)
            ADDR_LO:   rdata = count[DATA_W-1:0];
            ADDR_HI:   rdata = DATA_W'(mode_q.latch_live ? count[CNT_W-1:DATA_W] : hold_q);
            ADDR_MODE: rdata = DATA_W'(mode_q);
            default:   rdata = '0;
        endcase
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == ADDR_LO) |=> $stable(hold_q)); // R10
endmodule

// File: rtl/cnt24_core.sv
// Count engine: enable and direction selection, reload priority,
// terminal-count detection, RCAP flag and output pin.
// Priority: reset cmd > load cmd > index reload > terminal reload > step.
module cnt24_core
    import cnt24_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] pre_sel,
    input  logic [CNT_W-1:0] pre0,
    input  logic             cmd_reset,
    input  logic             cmd_load,
    input  logic             cmd_fire,
    input  logic             tick,
    input  logic             q_step,
    input  logic             q_up,
    input  logic             idx_s,
    input  logic             hw_en,
    output logic [CNT_W-1:0] count,
    output logic             rcap,
    output logic             cout
);
    logic [CNT_W-1:0] count_q, count_d;
    logic rcap_q, rcap_d, pend_q, pend_d, idx_q;
    logic hw_lvl, enabled, internal, raw_step, down, index_load, hit_zero;
    logic unused_bits;

    assign unused_bits = ^{mode.rsvd, mode.psel, mode.latch_live};

    // Select enable, step source and direction.
    always_comb begin
        unique case (mode.hw_src)
            2'd0:    hw_lvl = hw_en;
            2'd1:    hw_lvl = ~hw_en;
            2'd2:    hw_lvl = rcap_q;
            default: hw_lvl = ~rcap_q;
        endcase
        enabled    = (mode.en_ctl == 2'd1) | (mode.en_ctl[1] & hw_lvl);
        internal   = (mode.clk_src == CKS_INT);
        raw_step   = internal ? tick : q_step;
        down       = mode.dir_sw ? mode.dir_down : (~internal & ~q_up);
        index_load = idx_s & ~idx_q & (mode.autoload == AL_INDEX);
    end

    // Resolve the next count by priority and detect terminal count.
    always_comb begin
        count_d  = count_q;
        hit_zero = 1'b0;
        if (cmd_reset)        count_d = '0;
        else if (cmd_load)    count_d = pre0;
        else if (index_load)  count_d = pre_sel;
        else if (pend_q)      count_d = pre_sel;
        else if (enabled && raw_step) begin
            count_d  = down ? count_q - CNT_W'(1) : count_q + CNT_W'(1);
            hit_zero = down && count_q == CNT_W'(1);
        end
        pend_d = hit_zero && mode.autoload == AL_TC;
        rcap_d = cmd_fire ? 1'b0 : (hit_zero | rcap_q);
    end

    // Register count, flag, pending reload and index history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            rcap_q  <= 1'b1;
            pend_q  <= 1'b0;
            idx_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            rcap_q  <= rcap_d;
            pend_q  <= pend_d;
            idx_q   <= idx_s;
        end
    end

    assign count = count_q;
    assign rcap  = rcap_q;
    assign cout  = (mode.out_src ? (count_q == '0) : rcap_q) ^ mode.out_pol;

    AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> count_q == '0); // R4
    AST_LOAD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !cmd_reset) |=> count_q == $past(pre0)); // R4
    AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> !rcap_q); // R5
    AST_TC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !cmd_reset && !cmd_load && !index_load) |=> count_q == $past(pre_sel)); // R7
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_reset && !cmd_load && !index_load && !pend_q) |=>
        (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)
         || count_q == $past(count_q) - CNT_W'(1))); // R3
endmodule

// File: rtl/cnt24_channel.sv
// Top of one counter channel: synchronizes the asynchronous pins and
// connects the register window, quadrature decoder and count engine.
// Assumes a single clock domain for the bus, tick and enable inputs.
module cnt24_channel
    import cnt24_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_in,
    input  logic              quad_a,
    input  logic              quad_b,
    input  logic              index_in,
    input  logic              hw_enable,
    output logic              count_out
);
    logic [2:0]       pins_s;
    logic             q_step, q_up, rcap;
    logic [CNT_W-1:0] count, pre_sel, pre0;
    logic             cmd_reset, cmd_load, cmd_fire;
    mode_t            mode;
    logic             unused_rcap;

    assign unused_rcap = rcap;

    cnt24_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({index_in, quad_b, quad_a}), .q(pins_s)
    );

    cnt24_quad u_quad (
        .clk(clk), .rst_n(rst_n),
        .a_s(pins_s[0]), .b_s(pins_s[1]), .mult(mode.clk_src),
        .step(q_step), .up(q_up)
    );

    cnt24_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
        .count(count), .rdata(bus_rdata), .mode(mode),
        .pre_sel(pre_sel), .pre0(pre0),
        .cmd_reset(cmd_reset), .cmd_load(cmd_load), .cmd_fire(cmd_fire)
    );

    cnt24_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .pre_sel(pre_sel), .pre0(pre0),
        .cmd_reset(cmd_reset), .cmd_load(cmd_load), .cmd_fire(cmd_fire),
        .tick(tick_in), .q_step(q_step), .q_up(q_up),
        .idx_s(pins_s[2]), .hw_en(hw_enable),
        .count(count), .rcap(rcap), .cout(count_out)
    );
endmodule

// File: tb/cnt24_channel_bench.sv
module cnt24_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic        tick = 1'b0, qa = 1'b0, qb = 1'b0, idx = 1'b0, hw_en = 1'b0;
    wire  [15:0] rdata;
    wire         cout;

    int    n_checks = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    cnt24_channel u_cnt24_channel (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_en), .bus_rd(rd_en),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .tick_in(tick), .quad_a(qa), .quad_b(qb), .index_in(idx),
        .hw_enable(hw_en), .count_out(cout)
    );

    // Reference model state
    logic [23:0] m_cnt, m_pre0, m_pre1;
    logic [15:0] m_mode;
    logic [7:0]  m_hold;
    logic        m_rcap, m_pend;
    logic [2:0]  m_s1, m_s2, m_prev;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int qpos(input logic a, input logic b);
        case ({a, b})
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [15:0] mk(input int src, pol, al, hws, enc, cks, dir, dsw, lat, psel);
        return 16'(src) | 16'(pol << 1) | 16'(al << 2) | 16'(hws << 5) | 16'(enc << 7)
             | 16'(cks << 9) | 16'(dir << 11) | 16'(dsw << 12) | 16'(lat << 13) | 16'(psel << 14);
    endfunction

    // Cycle model, then compare one ns after the edge.
    always @(posedge clk) begin : model
        logic [23:0] psv, nxt;
        logic a_o, b_o, a_n, b_n, legal, qstep, qup, internal, raw, en, down, hw, hit, ctrl, irise;
        logic [15:0] exp_rd;
        logic        exp_co;
        if (!rst_n) begin
            m_cnt = 0; m_pre0 = 0; m_pre1 = 0; m_mode = 0; m_hold = 0;
            m_rcap = 1; m_pend = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            a_o = m_prev[0]; b_o = m_prev[1]; a_n = m_s2[0]; b_n = m_s2[1];
            legal = (a_o != a_n) != (b_o != b_n);
            qup = (qpos(a_n, b_n) == (qpos(a_o, b_o) + 1) % 4);
            internal = (m_mode[10:9] == 2'd3);
            case (m_mode[10:9])
                2'd0:    qstep = (a_o != a_n) && legal && !b_n;
                2'd1:    qstep = (a_o != a_n) && legal;
                2'd2:    qstep = legal;
                default: qstep = 0;
            endcase
            raw  = internal ? tick : qstep;
            down = m_mode[12] ? m_mode[11] : (internal ? 1'b0 : !qup);
            case (m_mode[6:5])
                2'd0:    hw = hw_en;
                2'd1:    hw = !hw_en;
                2'd2:    hw = m_rcap;
                default: hw = !m_rcap;
            endcase
            en = (m_mode[8:7] == 2'd1) || (m_mode[8:7] >= 2'd2 && hw);
            ctrl = wr_en && addr == 2'd3;
            psv = m_mode[14] ? m_pre1 : m_pre0;
            irise = m_s2[2] && !m_prev[2];
            hit = 0;
            if (ctrl && wdata[15])                        nxt = 0;
            else if (ctrl && wdata[14])                   nxt = m_pre0;
            else if (irise && m_mode[4:2] == 3'd4)        nxt = psv;
            else if (m_pend)                              nxt = psv;
            else if (en && raw) begin
                nxt = down ? m_cnt - 1 : m_cnt + 1;
                hit = down && m_cnt == 1;
            end else nxt = m_cnt;
            m_pend = hit && m_mode[4:2] == 3'd1;
            if (ctrl && wdata[3]) m_rcap = 0;
            else if (hit)         m_rcap = 1;
            if (wr_en && addr == 2'd0) begin
                if (m_mode[14]) m_pre1[15:0] = wdata; else m_pre0[15:0] = wdata;
            end
            if (wr_en && addr == 2'd1) begin
                if (m_mode[14]) m_pre1[23:16] = wdata[7:0]; else m_pre0[23:16] = wdata[7:0];
            end
            if (rd_en && addr == 2'd0) m_hold = m_cnt[23:16];
            if (wr_en && addr == 2'd2) m_mode = wdata;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = {idx, qb, qa};
            m_cnt = nxt;
        end
        #1;
        case (addr)
            2'd0:    exp_rd = m_cnt[15:0];
            2'd1:    exp_rd = {8'h00, m_mode[13] ? m_cnt[23:16] : m_hold};
            2'd2:    exp_rd = m_mode;
            default: exp_rd = 16'h0;
        endcase
        exp_co = (m_mode[0] ? (m_cnt == 0) : m_rcap) ^ m_mode[1];
        check(rdata === exp_rd, cur_req, "model rdata", 32'(rdata), 32'(exp_rd));
        check(cout === exp_co, cur_req, "model cout", 32'(cout), 32'(exp_co));
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0; wdata = 16'h0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string req);
        addr = a; rd_en = 1'b1;
        #1;
        check(rdata === exp, req, "read", 32'(rdata), 32'(exp));
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd0;
    endtask

    task automatic chk_cout(input logic exp, input string req);
        check(cout === exp, req, "cout", 32'(cout), 32'(exp));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic quad(input logic a, input logic b);
        qa = a; qb = b;
        idle(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 map
        cur_req = "R1";
        chk_cout(1'b1, "R1");
        rd_chk(2'd2, 16'h0000, "R1");
        rd_chk(2'd0, 16'h0000, "R1");
        rd_chk(2'd1, 16'h0000, "R1");
        rd_chk(2'd3, 16'h0000, "R2");

        // R6 banked preload window, R4 commands
        cur_req = "R6";
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h3456);
        wr(2'd1, 16'hAB12);
        wr(2'd2, 16'h4000);
        wr(2'd0, 16'hBEEF);
        wr(2'd1, 16'h0077);
        rd_chk(2'd2, 16'h4000, "R2");
        cur_req = "R4";
        wr(2'd3, 16'h4000);
        rd_chk(2'd0, 16'h3456, "R4");
        rd_chk(2'd1, 16'h0012, "R6");
        wr(2'd3, 16'h8000);
        rd_chk(2'd0, 16'h0000, "R4");
        wr(2'd3, 16'h4000);
        wr(2'd3, 16'hC000);
        rd_chk(2'd0, 16'h0000, "R4");

        // R3 internal tick, direction, enables
        cur_req = "R3";
        wr(2'd2, mk(0,0,0,0,1,3,0,1,0,0));
        ticks(5);
        rd_chk(2'd0, 16'd5, "R3");
        wr(2'd2, mk(0,0,0,0,1,3,1,1,0,0));
        ticks(2);
        rd_chk(2'd0, 16'd3, "R3");
        wr(2'd2, mk(0,0,0,0,0,3,0,1,0,0));
        ticks(3);
        rd_chk(2'd0, 16'd3, "R3");
        wr(2'd2, mk(0,0,0,0,2,3,0,1,0,0));
        ticks(2);
        hw_en = 1'b1;
        ticks(2);
        rd_chk(2'd0, 16'd5, "R3");
        wr(2'd2, mk(0,0,0,1,2,3,0,1,0,0));
        ticks(1);
        hw_en = 1'b0;
        ticks(1);
        rd_chk(2'd0, 16'd6, "R3");

        // R12 one-shot with R5 flag and R11 polarity
        cur_req = "R12";
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'd4);
        wr(2'd1, 16'd0);
        wr(2'd2, mk(0,1,1,3,2,3,1,1,0,0));
        wr(2'd3, 16'h4000);
        chk_cout(1'b0, "R11");
        wr(2'd3, 16'h0008);
        chk_cout(1'b1, "R5");
        ticks(10);
        rd_chk(2'd0, 16'd4, "R12");
        chk_cout(1'b0, "R12");

        // R7 reload from the bank picked by the select bit
        cur_req = "R7";
        wr(2'd2, mk(0,0,1,0,1,3,1,1,0,1));
        ticks(4);
        idle(2);
        rd_chk(2'd0, 16'hBEEF, "R7");
        rd_chk(2'd1, 16'h0077, "R7");

        // R5 clear and terminal count in the same cycle
        cur_req = "R5";
        wr(2'd2, mk(0,0,0,0,1,3,1,1,0,0));
        wr(2'd0, 16'd1);
        wr(2'd1, 16'd0);
        wr(2'd3, 16'h4000);
        wr(2'd3, 16'h0008);
        chk_cout(1'b0, "R5");
        tick = 1'b1;
        wr(2'd3, 16'h0008);
        tick = 1'b0;
        chk_cout(1'b0, "R5");
        rd_chk(2'd0, 16'd0, "R5");
        wr(2'd3, 16'h4000);
        ticks(1);
        chk_cout(1'b1, "R5");

        // R8 quadrature decoding
        cur_req = "R8";
        wr(2'd2, mk(0,0,0,0,1,2,0,0,0,0));
        wr(2'd3, 16'h8000);
        quad(1,0); quad(1,1); quad(0,1); quad(0,0);
        rd_chk(2'd0, 16'd4, "R8");
        quad(0,1); quad(1,1); quad(1,0); quad(0,0);
        rd_chk(2'd0, 16'd0, "R8");
        wr(2'd2, mk(0,0,0,0,1,1,0,0,0,0));
        quad(1,0); quad(1,1); quad(0,1); quad(0,0);
        rd_chk(2'd0, 16'd2, "R8");
        wr(2'd2, mk(0,0,0,0,1,0,0,0,0,0));
        quad(1,0); quad(1,1); quad(0,1); quad(0,0);
        rd_chk(2'd0, 16'd3, "R8");
        quad(1,1); quad(0,0);
        rd_chk(2'd0, 16'd3, "R8");
        cur_req = "R3";
        wr(2'd2, mk(0,0,0,0,1,3,0,0,0,0));
        ticks(2);
        rd_chk(2'd0, 16'd5, "R3");

        // R9 index reload, colliding with a quadrature step
        cur_req = "R9";
        wr(2'd2, mk(0,0,4,0,1,2,0,0,0,0));
        wr(2'd0, 16'd16);
        wr(2'd1, 16'd0);
        idx = 1'b1;
        idle(4);
        rd_chk(2'd0, 16'd16, "R9");
        idx = 1'b0;
        idle(4);
        wr(2'd3, 16'h8000);
        idx = 1'b1; qa = 1'b1;
        idle(4);
        rd_chk(2'd0, 16'd16, "R9");
        idx = 1'b0;

        // R10 high-byte latch
        cur_req = "R10";
        wr(2'd2, mk(0,0,0,0,0,3,0,1,0,0));
        wr(2'd0, 16'h3456);
        wr(2'd1, 16'h0012);
        wr(2'd3, 16'h4000);
        rd_chk(2'd0, 16'h3456, "R10");
        wr(2'd3, 16'h8000);
        rd_chk(2'd1, 16'h0012, "R10");
        rd_chk(2'd0, 16'h0000, "R10");
        rd_chk(2'd1, 16'h0000, "R10");
        wr(2'd2, mk(0,0,0,0,0,3,0,1,1,0));
        wr(2'd3, 16'h4000);
        rd_chk(2'd1, 16'h0012, "R10");

        // R11 zero-flag output source and polarity
        cur_req = "R11";
        wr(2'd2, mk(1,0,0,0,0,3,0,1,0,0));
        chk_cout(1'b0, "R11");
        wr(2'd3, 16'h8000);
        chk_cout(1'b1, "R11");
        wr(2'd2, mk(1,1,0,0,0,3,0,1,0,0));
        chk_cout(1'b0, "R11");
        idle(2);

        finish_run();
    end
endmodule